// File: doc/BRIEF.md
# Multi-Channel Bus Request Arbiter with Hold Handshake

This block decides which of several DMA request lines gets the single shared system bus. While any enabled channel is asking, it raises a hold request towards the processor and waits. Once the processor answers with hold acknowledge, it drives low the active-low acknowledge line of exactly one winning channel. That channel keeps the bus until the transfer engine pulses `xfer_done`.

If other enabled channels are still asking when a transfer ends, the bus is not released. The next winner is granted in the cycle that follows, so the transfers run as one continuous burst. When nothing is left, the hold request drops.

The winner comes from one of two priority schemes, chosen through a write-only mode register:
- **Fixed:** the lowest channel index always wins.
- **Rotating:** the channel just served falls to the bottom, and the channel after it moves to the top.

The same write also sets a per-channel enable mask. The block has no data stream. Every pin is a plain level or strobe, so there is no back-pressure to manage.

Top module: `dma_grant_arbiter`

## Requirements
- R1: After reset, `hold_req` is 0 and every `dack_n` bit is 1. The mode is fixed priority and all channels are disabled, so requests are ignored until a mode write enables them.
- R2: A request on a channel whose enable bit (`cfg_chan_en[i]`, bit i for channel i) is 0 never raises `hold_req` and never receives an acknowledge.
- R3: When `hold_req` is 0 and an enabled request is sampled at a clock edge, `hold_req` is 1 after that edge. It stays 1 while the arbiter waits for acknowledge.
- R4: No `dack_n` bit is 0 in any cycle in which `hold_ack` is 0.
- R5: When `hold_ack` is sampled high while the arbiter is waiting with a request pending, the winner's `dack_n` bit is 0 after that edge.
- R6: In fixed mode (`cfg_rotate` = 0), the pending enabled channel with the lowest index wins.
- R7: In rotating mode (`cfg_rotate` = 1), after channel g is served, channel (g+1) mod N has the highest priority, and the order continues upwards with wrap-around, leaving g lowest.
- R8: At most one `dack_n` bit is 0 at any time.
- R9: While a channel holds the grant, `dack_n` does not change until an edge at which `xfer_done` is sampled high. A newly arriving higher-priority request does not pre-empt the grant.
- R10: If enabled requests remain when `xfer_done` is sampled, `hold_req` stays 1 and the next winner's `dack_n` goes low right after that edge, with no cycle in which all `dack_n` bits are 1.
- R11: If no enabled request remains, `hold_req` drops at the next edge. This applies when `xfer_done` is sampled, and also while waiting for acknowledge.
- R12: A mode write (`cfg_wr` = 1) loads `cfg_rotate` and `cfg_chan_en` at the clock edge and restarts the rotating order with channel 0 highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_rotate | input | 1 | Written mode: 1 rotating, 0 fixed |
| cfg_chan_en | input | NCH | Written per-channel enable mask |
| dreq | input | NCH | Channel request lines, active high |
| xfer_done | input | 1 | Pulse marking the end of the current transfer |
| hold_ack | input | 1 | Processor grants the bus |
| hold_req | output | 1 | Request for the bus towards the processor |
| dack_n | output | NCH | Per-channel acknowledge, active low |

## Verification
The bench builds the block with its default of four channels. This is small enough for the rotating order to wrap from channel 3 back to channel 0 within a single burst, and for both pointer paths to be exercised: advancing past the served channel, and being restarted by a mode write. With four lines, every request mask tried can be checked against an order worked out by hand. This covers disabled channels mixed with enabled ones, and a late higher-priority request that must wait.

// File: rtl/dmaarb_pkg.sv
`timescale 1ns/1ps
package dmaarb_pkg;
  // Sequencer phases: no bus wanted, bus wanted but not yet given, bus owned
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dmaarb_modereg.sv
`timescale 1ns/1ps
module dmaarb_modereg #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           rotate_in,
  input  logic [NCH-1:0] en_in,
  output logic           rotate,
  output logic [NCH-1:0] en
);
  // Write-only: the stored mode is consumed internally, never returned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rotate <= 1'b0;
      en     <= '0;
    end else if (wr) begin
      rotate <= rotate_in;
      en     <= en_in;
    end
  end
endmodule

// File: rtl/dmaarb_pick.sv
`timescale 1ns/1ps
module dmaarb_pick #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  base,
  output logic           any,
  output logic [IW-1:0]  win
);
  localparam logic [IW:0] NCH_W = (IW+1)'(NCH);

  logic [IW-1:0] cand [NCH];
  logic [NCH-1:0] hit;

  // Offset k from the highest-priority channel, wrapped into range
  for (genvar k = 0; k < NCH; k++) begin : g_off
    logic [IW:0] sum;
    assign sum      = {1'b0, base} + (IW+1)'(k);
    assign cand[k]  = (sum >= NCH_W) ? IW'(sum - NCH_W) : IW'(sum);
    assign hit[k]   = req[cand[k]];
  end

  always_comb begin
    any = |hit;
    win = cand[0];
    for (int k = NCH - 1; k >= 0; k--) begin
      if (hit[k]) win = cand[k];
    end
  end
endmodule

// File: rtl/dmaarb_seq.sv
`timescale 1ns/1ps
module dmaarb_seq
  import dmaarb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          rotate,
  input  logic          hold_ack,
  input  logic          xfer_done,
  output logic [IW-1:0] pick_base,
  input  logic          pick_any,
  input  logic [IW-1:0] pick_win,
  output logic          hold_req,
  output logic          owning,
  output logic [IW-1:0] grant
);
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  arb_state_e    st;
  logic [IW-1:0] ptr;
  logic [IW-1:0] after_grant;

  assign after_grant = (grant == LAST) ? '0 : grant + 1'b1;

  // While owning, the candidate order is the one that applies once the
  // current transfer ends; otherwise it is the stored rotation point.
  always_comb begin
    if (!rotate)            pick_base = '0;
    else if (st == ARB_OWN) pick_base = after_grant;
    else                    pick_base = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ARB_IDLE;
      grant <= '0;
      ptr   <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: if (pick_any) st <= ARB_WAIT;
        ARB_WAIT: begin
          if (!pick_any) st <= ARB_IDLE;
          else if (hold_ack) begin
            st    <= ARB_OWN;
            grant <= pick_win;
          end
        end
        ARB_OWN: begin
          if (xfer_done) begin
            ptr <= after_grant;
            if (pick_any) grant <= pick_win;
            else          st    <= ARB_IDLE;
          end
        end
        default: st <= ARB_IDLE;
      endcase
      if (cfg_wr) ptr <= '0;
    end
  end

  assign hold_req = (st != ARB_IDLE);
  assign owning   = (st == ARB_OWN);
endmodule

// File: rtl/dma_grant_arbiter.sv
`timescale 1ns/1ps
module dma_grant_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           cfg_rotate,
  input  logic [NCH-1:0] cfg_chan_en,
  input  logic [NCH-1:0] dreq,
  input  logic           xfer_done,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [NCH-1:0] dack_n
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           rotate;
  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] live_req;
  logic [IW-1:0]  pick_base;
  logic           pick_any;
  logic [IW-1:0]  pick_win;
  logic           owning;
  logic [IW-1:0]  grant;

  dmaarb_modereg #(.NCH(NCH)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .rotate_in(cfg_rotate), .en_in(cfg_chan_en),
    .rotate(rotate), .en(chan_en)
  );

  assign live_req = dreq & chan_en;

  dmaarb_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req(live_req), .base(pick_base), .any(pick_any), .win(pick_win)
  );

  dmaarb_seq #(.NCH(NCH), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .rotate(rotate),
    .hold_ack(hold_ack), .xfer_done(xfer_done),
    .pick_base(pick_base), .pick_any(pick_any), .pick_win(pick_win),
    .hold_req(hold_req), .owning(owning), .grant(grant)
  );

  // Acknowledge only while the processor keeps the bus released
  for (genvar i = 0; i < NCH; i++) begin : g_ack
    assign dack_n[i] = ~(owning && hold_ack && (grant == IW'(i)));
  end
endmodule

// File: rtl/dma_grant_arbiter_chk.sv
`timescale 1ns/1ps
module dma_grant_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dreq,
  input logic [NCH-1:0] chan_en,
  input logic           xfer_done,
  input logic           hold_ack,
  input logic           hold_req,
  input logic [NCH-1:0] dack_n
);
  logic [NCH-1:0] ones;
  assign ones = '1;

  assert_ack_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack |-> dack_n == ones);

  assert_single_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  assert_hold_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && |(dreq & chan_en)) |=> hold_req);

  assert_grant_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && $past(hold_ack) && !$past(xfer_done) &&
     dack_n != ones && $past(dack_n) != ones) |-> dack_n == $past(dack_n));

  assert_done_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && hold_ack && dack_n != ones && !(|(dreq & chan_en))) |=> !hold_req);

  assert_wait_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && hold_ack && dack_n == ones && !(|(dreq & chan_en))) |=> !hold_req);
endmodule

bind dma_grant_arbiter dma_grant_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dreq(dreq), .chan_en(chan_en),
  .xfer_done(xfer_done), .hold_ack(hold_ack), .hold_req(hold_req),
  .dack_n(dack_n)
);

// File: tb/dma_grant_arbiter_test.sv
`timescale 1ns/1ps
module dma_grant_arbiter_test;
  localparam int NCH  = 4;
  localparam int XLEN = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, cfg_wr, cfg_rotate, xfer_done, hold_ack;
  logic [NCH-1:0] cfg_chan_en, dreq, dack_n;
  logic           hold_req;

  dma_grant_arbiter #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rotate(cfg_rotate),
    .cfg_chan_en(cfg_chan_en), .dreq(dreq), .xfer_done(xfer_done),
    .hold_ack(hold_ack), .hold_req(hold_req), .dack_n(dack_n)
  );

  int tests = 0, fails = 0;
  int exp_q[$];
  bit auto_ack = 0;
  bit dev_on   = 0;
  bit rot_m    = 0;
  int base_m   = 0;
  int dcnt     = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chan_of(input logic [NCH-1:0] dn);
    for (int i = 0; i < NCH; i++) if (!dn[i]) return i;
    return -1;
  endfunction

  function automatic int model_pick(input logic [NCH-1:0] m, input int b);
    for (int k = 0; k < NCH; k++) if (m[(b + k) % NCH]) return (b + k) % NCH;
    return -1;
  endfunction

  // Processor model: follows the hold request shortly after each edge
  always @(posedge clk) begin
    #1;
    if (auto_ack) hold_ack = hold_req;
  end

  // Device model: ends each transfer after XLEN cycles and withdraws its request
  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 1'b0;
      dcnt = 0;
    end else if (dev_on && dack_n != '1) begin
      dcnt++;
      if (dcnt >= XLEN) begin
        xfer_done = 1'b1;
        dreq[chan_of(dack_n)] = 1'b0;
      end
    end
  end

  // Monitor: each new grant is popped from the scoreboard and compared
  logic [NCH-1:0] prev_dn = '1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dack_n != prev_dn && dack_n != '1) begin
        if (exp_q.size() == 0) chk(1'b0, "R6/R7 unexpected grant", chan_of(dack_n), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(chan_of(dack_n) == e, "R6/R7 grant order", chan_of(dack_n), e);
        end
      end
      if ($countones(~dack_n) > 1) chk(1'b0, "R8 acknowledges low", $countones(~dack_n), 1);
      if (!hold_ack && dack_n != '1) chk(1'b0, "R4 ack without hold_ack", chan_of(dack_n), -1);
      prev_dn = dack_n;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic wcfg(input bit rot, input logic [NCH-1:0] en);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rotate = rot; cfg_chan_en = en;
    @(negedge clk);
    cfg_wr = 1'b0;
    rot_m = rot; base_m = 0;
  endtask

  task automatic wait_done(input string tag);
    int gaps = 0;
    bit started = 0;
    bit ended = 0;
    for (int n = 0; n < 400; n++) begin
      step(1);
      if (dack_n != '1) started = 1;
      if (started && exp_q.size() > 0 && (dack_n == '1 || !hold_req)) gaps++;
      if (exp_q.size() == 0 && dack_n == '1) begin ended = 1; break; end
    end
    chk(ended, {tag, " R10 burst completes"}, ended, 1);
    chk(gaps == 0, {tag, " R10 no bus gap inside burst"}, gaps, 0);
    chk(hold_req == 1'b0, {tag, " R11 hold drops after last transfer"}, hold_req, 0);
  endtask

  // Driver: predicts the service order, queues it, raises the requests
  task automatic run_burst(input logic [NCH-1:0] mask, input string tag);
    logic [NCH-1:0] m = mask;
    while (m != '0) begin
      int w;
      w = model_pick(m, rot_m ? base_m : 0);
      exp_q.push_back(w);
      m[w] = 1'b0;
      if (rot_m) base_m = (w + 1) % NCH;
    end
    @(negedge clk);
    dreq = dreq | mask;
    wait_done(tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R1 run hung actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_rotate = 0; cfg_chan_en = '0;
    dreq = '0; xfer_done = 0; hold_ack = 0;
    step(3);
    rst_n = 1;
    step(1);
    chk(hold_req == 1'b0, "R1 hold_req after reset", hold_req, 0);
    chk(dack_n == '1, "R1 dack_n after reset", dack_n, 4'hF);

    // All channels disabled by reset
    dreq = '1;
    step(4);
    chk(hold_req == 1'b0, "R1 requests ignored before enable", hold_req, 0);
    dreq = '0;
    dev_on = 1;

    // R2: disabled channel 2
    wcfg(1'b0, 4'b1011);
    dreq = 4'b0100;
    step(4);
    chk(hold_req == 1'b0, "R2 disabled channel raises no hold", hold_req, 0);
    chk(dack_n == '1, "R2 disabled channel not acknowledged", dack_n, 4'hF);
    dreq = '0;
    step(1);

    // R3/R4/R5 with a manually held acknowledge, fixed order 1 then 3
    exp_q.push_back(1); exp_q.push_back(3);
    dreq = 4'b1010;
    step(1);
    chk(hold_req == 1'b1, "R3 hold_req rises", hold_req, 1);
    step(3);
    chk(hold_req == 1'b1, "R3 hold_req held while waiting", hold_req, 1);
    chk(dack_n == '1, "R4 no ack while hold_ack low", dack_n, 4'hF);
    hold_ack = 1'b1;
    step(1);
    chk(dack_n == 4'b1101, "R5 winner acknowledged after hold_ack", dack_n, 4'b1101);
    auto_ack = 1;
    wait_done("R6 fixed 1010");

    // R7 rotating order, R12 mode write
    wcfg(1'b1, 4'b1111);
    run_burst(4'b1111, "R7 rot 1111");
    run_burst(4'b0101, "R7 rot 0101");
    run_burst(4'b1001, "R7 rot 1001 wrap");
    run_burst(4'b0110, "R7 rot 0110");
    wcfg(1'b1, 4'b1111);
    run_burst(4'b1001, "R12 rotation restarted");

    // Back to fixed priority
    wcfg(1'b0, 4'b1111);
    run_burst(4'b1001, "R12 fixed 1001");
    run_burst(4'b1110, "R6 fixed 1110");

    // R9: a late higher-priority request does not pre-empt
    exp_q.push_back(2);
    @(negedge clk);
    dreq = 4'b0100;
    for (int n = 0; n < 50; n++) begin
      step(1);
      if (dack_n == 4'b1011) break;
    end
    chk(dack_n == 4'b1011, "R9 channel 2 granted", dack_n, 4'b1011);
    exp_q.push_back(0);
    dreq[0] = 1'b1;
    step(1);
    chk(dack_n == 4'b1011, "R9 grant held before transfer end", dack_n, 4'b1011);
    wait_done("R9 late request");

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule